// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Port Emulator

This block stands in for a single-channel successive-approximation converter on the device side of a serial link, so that a host controller can be verified against something that frames, pads and shifts data the way a real converter would. The controller drives an active-low chip select and a serial clock. A parallel sample word stands in for the analog input. The block answers on a serial data line, given here as a data bit plus an output enable, and raises a flag that shows whether the sampling stage is tracking or holding.

Chip select and the serial clock are sampled on the block's own system clock, and their edges are found there. A falling chip select captures the sample and the resolution mode, drives the first padding zero and puts the sampler into hold. Later bits follow the falling edges of the serial clock. Each frame is sixteen serial clocks long. In wide mode it holds four zeros and then the 12-bit result. In narrow mode it holds four zeros, the 10-bit result and two zeros. Data goes out most significant bit first, in straight binary. Every output is a register, so it changes one system clock after the input edge is sampled.

Top module: `sar_serial_emu`

## Requirements
- R1: After reset, sdo_oe is 0, sdo is 0 and track is 1.
- R2: One system clock after a falling chip select is sampled, sdo_oe is 1, sdo is 0 (the first padding zero) and track is 0.
- R3: With mode_10b = 0 captured, the value on sdo after the k-th serial-clock fall (k = 1..15) is bit 15-k of {4'b0000, sample[11:0]}.
- R4: With mode_10b = 1 captured, the value on sdo after the k-th fall (k = 1..15) is bit 15-k of {4'b0000, sample[9:0], 2'b00}. sample[11:10] have no effect.
- R5: The 16th serial-clock fall of a frame clears sdo_oe. Further serial-clock edges before chip select rises leave it at 0.
- R6: track stays 0 through the 13th fall and becomes 1 on the first serial-clock rise after the 13th fall. While track is 0, sdo_oe is 1.
- R7: A rise of chip select before the 16th fall ends the frame. One system clock later sdo_oe is 0 and track is 1.
- R8: While chip select is high, serial-clock edges have no effect. sdo_oe stays 0 and the next frame starts from its first bit.
- R9: A new falling chip select, also one that follows an aborted frame, restarts the bit count and sends a frame built from a freshly captured sample.
- R10: Changes to sample_in and mode_10b after the falling chip select do not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; chip select and serial clock are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the controller |
| sclk | input | 1 | Serial clock from the controller |
| mode_10b | input | 1 | 0 selects the 12-bit frame, 1 selects the 10-bit frame; captured at chip-select fall |
| sample_in | input | 12 | Parallel word standing in for the analog input, straight binary |
| sdo | output | 1 | Serial data bit, 0 whenever sdo_oe is 0 |
| sdo_oe | output | 1 | Output enable of the serial data line; 0 models high impedance |
| track | output | 1 | 1 while the sampler tracks, 0 while it holds |

## Verification
If the fall counter goes wrong, the failure shows first on sdo as a bit moved by one position. A few serial clocks later it shows on sdo_oe, which drops a clock early or late, or on track, which rises on the wrong rise. If the frame register loads a bad value, the wrong bit appears on the first serial-clock fall that reaches that bit position. The 10-bit trailing zeros show up only on falls 14 and 15. A stale active state after an abort, or edges counted while chip select is high, give no sign until the next frame: its sdo_oe or track timing is then off. For this reason each abort and each idle-clock scenario is followed by a full frame that is checked bit by bit.

// File: rtl/sar_emu_pkg.sv
package sar_emu_pkg;
   localparam int unsigned DEF_FRAME_LEN   = 16;
   localparam int unsigned DEF_LEAD_ZEROS  = 4;
   localparam int unsigned DEF_RES_HI      = 12;
   localparam int unsigned DEF_RES_LO      = 10;
   localparam int unsigned DEF_TRACK_AFTER = 13;

   typedef enum logic {
      RES_WIDE   = 1'b0,
      RES_NARROW = 1'b1
   } res_mode_e;
endpackage

// File: rtl/sar_emu_edge.sv
module sar_emu_edge #(
   parameter bit IDLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= din;
   end

   assign rise = din & ~prev_q;
   assign fall = ~din & prev_q;
endmodule

// File: rtl/sar_emu_frame.sv
module sar_emu_frame
   import sar_emu_pkg::*;
#(
   parameter int unsigned FRAME_LEN  = DEF_FRAME_LEN,
   parameter int unsigned LEAD_ZEROS = DEF_LEAD_ZEROS,
   parameter int unsigned RES_HI     = DEF_RES_HI,
   parameter int unsigned RES_LO     = DEF_RES_LO
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  res_mode_e         mode,
   input  logic [RES_HI-1:0] sample,
   output logic              msb
);
   localparam int unsigned TRAIL_LO = FRAME_LEN - LEAD_ZEROS - RES_LO;

   logic [FRAME_LEN-1:0] wide_w;
   logic [FRAME_LEN-1:0] load_w;
   logic [FRAME_LEN-1:0] frame_q;

   // wide result sits right-aligned: lead zeros come from zero extension
   assign wide_w = FRAME_LEN'(sample);

   generate
      if (RES_LO < RES_HI) begin : g_dual
         logic [FRAME_LEN-1:0] narrow_w;
         assign narrow_w = FRAME_LEN'(sample[RES_LO-1:0]) << TRAIL_LO;
         assign load_w   = (mode == RES_NARROW) ? narrow_w : wide_w;
      end else begin : g_single
         logic unused_mode;
         assign unused_mode = mode;
         assign load_w      = wide_w;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     frame_q <= '0;
      else if (load)  frame_q <= load_w;
      else if (shift) frame_q <= {frame_q[FRAME_LEN-2:0], 1'b0};
   end

   assign msb = frame_q[FRAME_LEN-1];
endmodule

// File: rtl/sar_emu_seq.sv
module sar_emu_seq
   import sar_emu_pkg::*;
#(
   parameter int unsigned FRAME_LEN   = DEF_FRAME_LEN,
   parameter int unsigned TRACK_AFTER = DEF_TRACK_AFTER
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_fall,
   input  logic cs_rise,
   input  logic sclk_fall,
   input  logic sclk_rise,
   output logic load,
   output logic shift,
   output logic drive,
   output logic track
);
   localparam int unsigned CW = $clog2(FRAME_LEN + 1);

   logic [CW-1:0] cnt_q;
   logic          active_q;
   logic          drive_q;
   logic          track_q;

   assign load  = cs_fall;
   assign shift = active_q & sclk_fall & ~cs_fall & ~cs_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
         drive_q  <= 1'b0;
         track_q  <= 1'b1;
      end else if (cs_fall) begin
         cnt_q    <= '0;
         active_q <= 1'b1;
         drive_q  <= 1'b1;
         track_q  <= 1'b0;
      end else if (cs_rise) begin
         active_q <= 1'b0;
         drive_q  <= 1'b0;
         track_q  <= 1'b1;
      end else if (active_q) begin
         if (sclk_fall) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(FRAME_LEN - 1)) begin
               active_q <= 1'b0;
               drive_q  <= 1'b0;
            end
         end
         if (sclk_rise && cnt_q >= CW'(TRACK_AFTER)) track_q <= 1'b1;
      end
   end

   assign drive = drive_q;
   assign track = track_q;

   // the fall count never passes the frame length
   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(FRAME_LEN));

   // holding only happens inside a driven frame
   assert_hold_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !track_q |-> drive_q);
endmodule

// File: rtl/sar_serial_emu.sv
module sar_serial_emu
   import sar_emu_pkg::*;
#(
   parameter int unsigned FRAME_LEN   = DEF_FRAME_LEN,
   parameter int unsigned LEAD_ZEROS  = DEF_LEAD_ZEROS,
   parameter int unsigned RES_HI      = DEF_RES_HI,
   parameter int unsigned RES_LO      = DEF_RES_LO,
   parameter int unsigned TRACK_AFTER = DEF_TRACK_AFTER
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              mode_10b,
   input  logic [RES_HI-1:0] sample_in,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              track
);
   initial begin
      assert (LEAD_ZEROS >= 1 && LEAD_ZEROS + RES_HI == FRAME_LEN)
         else $fatal(1, "frame length must equal lead zeros plus wide result");
      assert (RES_LO >= 1 && RES_LO <= RES_HI)
         else $fatal(1, "narrow result must not exceed wide result");
      assert (TRACK_AFTER >= 1 && TRACK_AFTER < FRAME_LEN)
         else $fatal(1, "track point must fall inside the frame");
   end

   logic cs_rise, cs_fall, sclk_rise, sclk_fall;
   logic load, shift, drive, msb;
   res_mode_e mode;

   assign mode = mode_10b ? RES_NARROW : RES_WIDE;

   sar_emu_edge #(.IDLE(1'b1)) u_cs_edge (
      .clk(clk), .rst_n(rst_n), .din(cs_n), .rise(cs_rise), .fall(cs_fall));

   sar_emu_edge #(.IDLE(1'b1)) u_sclk_edge (
      .clk(clk), .rst_n(rst_n), .din(sclk), .rise(sclk_rise), .fall(sclk_fall));

   sar_emu_seq #(.FRAME_LEN(FRAME_LEN), .TRACK_AFTER(TRACK_AFTER)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cs_fall(cs_fall), .cs_rise(cs_rise),
      .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
      .load(load), .shift(shift), .drive(drive), .track(track));

   sar_emu_frame #(.FRAME_LEN(FRAME_LEN), .LEAD_ZEROS(LEAD_ZEROS),
                   .RES_HI(RES_HI), .RES_LO(RES_LO)) u_frame (
      .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
      .mode(mode), .sample(sample_in), .msb(msb));

   assign sdo_oe = drive;
   assign sdo    = drive & msb;

   assert_launch_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |=> (sdo_oe && !sdo && !track));

   assert_abort_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> track);

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (!sdo_oe && !sdo));
endmodule

// File: tb/sar_serial_emu_tb_top.sv
module sar_serial_emu_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b1;
   logic        mode_10b = 1'b0;
   logic [11:0] sample_in = '0;
   logic        sdo, sdo_oe, track;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   sar_serial_emu dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
      .mode_10b(mode_10b), .sample_in(sample_in),
      .sdo(sdo), .sdo_oe(sdo_oe), .track(track));

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // chip select falls, then nfall serial clocks; scramble changes inputs mid-frame
   task automatic run_frame(input logic [11:0] smp, input logic m10, input int nfall,
                            input bit scramble, input string rq);
      logic [15:0] exp;
      exp = m10 ? {4'b0000, smp[9:0], 2'b00} : {4'b0000, smp};
      sample_in = smp;
      mode_10b  = m10;
      cs_n = 1'b0; step();
      chk(sdo_oe, 1'b1, "R2", "oe after select");
      chk(sdo, 1'b0, "R2", "first zero");
      chk(track, 1'b0, "R2", "hold after select");
      for (int k = 1; k <= nfall; k++) begin
         sclk = 1'b0;
         if (scramble && k == 3) begin
            sample_in = ~smp;
            mode_10b  = ~m10;
         end
         step();
         if (k < 16) begin
            chk(sdo_oe, 1'b1, rq, $sformatf("oe after fall %0d", k));
            chk(sdo, exp[16-k-1], rq, $sformatf("bit after fall %0d", k));
         end else begin
            chk(sdo_oe, 1'b0, "R5", "oe after fall 16");
            chk(sdo, 1'b0, "R5", "data after fall 16");
         end
         chk(track, k >= 14, "R6", $sformatf("track after fall %0d", k));
         sclk = 1'b1; step();
         chk(track, k >= 13, "R6", $sformatf("track after rise %0d", k));
      end
   endtask

   task automatic end_frame(input string rq);
      cs_n = 1'b1; step();
      chk(sdo_oe, 1'b0, rq, "oe after deselect");
      chk(track, 1'b1, rq, "track after deselect");
      step(); step();
   endtask

   task automatic t_reset();
      chk(sdo_oe, 1'b0, "R1", "reset oe");
      chk(sdo, 1'b0, "R1", "reset data");
      chk(track, 1'b1, "R1", "reset track");
   endtask

   task automatic t_wide();
      run_frame(12'hA5C, 1'b0, 16, 1'b0, "R3"); end_frame("R5");
      run_frame(12'hFFF, 1'b0, 16, 1'b0, "R3"); end_frame("R5");
      run_frame(12'h000, 1'b0, 16, 1'b0, "R3"); end_frame("R5");
      run_frame(12'h801, 1'b0, 16, 1'b0, "R3");
      // extra clocks after the frame keep the line released
      for (int i = 0; i < 3; i++) begin
         sclk = 1'b0; step(); chk(sdo_oe, 1'b0, "R5", "oe on extra fall");
         sclk = 1'b1; step(); chk(track, 1'b1, "R5", "track on extra rise");
      end
      end_frame("R5");
   endtask

   task automatic t_narrow();
      run_frame(12'hFFF, 1'b1, 16, 1'b0, "R4"); end_frame("R4");
      run_frame(12'hC01, 1'b1, 16, 1'b0, "R4"); end_frame("R4");
      run_frame(12'h2AA, 1'b1, 16, 1'b0, "R4"); end_frame("R4");
   endtask

   task automatic t_abort();
      run_frame(12'h5A5, 1'b0, 5, 1'b0, "R3");
      end_frame("R7");
      run_frame(12'h3C3, 1'b0, 13, 1'b0, "R3");
      end_frame("R7");
   endtask

   task automatic t_idle();
      for (int i = 0; i < 20; i++) begin
         sclk = ~sclk; step();
         chk(sdo_oe, 1'b0, "R8", "oe with select high");
         chk(sdo, 1'b0, "R8", "data with select high");
      end
      sclk = 1'b1; step();
      run_frame(12'h96E, 1'b0, 16, 1'b0, "R8"); end_frame("R8");
   endtask

   task automatic t_restart();
      run_frame(12'hFFF, 1'b1, 7, 1'b0, "R4");
      cs_n = 1'b1; step();
      run_frame(12'h123, 1'b0, 16, 1'b0, "R9"); end_frame("R9");
   endtask

   task automatic t_capture();
      run_frame(12'h6B9, 1'b0, 16, 1'b1, "R10"); end_frame("R10");
      run_frame(12'h3F0, 1'b1, 16, 1'b1, "R10"); end_frame("R10");
   endtask

   initial begin
      step(); step();
      t_reset();
      rst_n = 1'b1;
      step(); step();
      t_reset();
      t_wide();
      t_narrow();
      t_abort();
      t_idle();
      t_restart();
      t_capture();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule